// File: doc/BRIEF.md
# Vectored Interrupt Controller with Processor Acknowledge

This block gathers interrupt requests from a small set of internal strobes and from up to sixteen external pins, records each one in a status register, masks them with an enable register and raises a single request line to the processor. Internal sources occupy the low status bits. External input i always sits at status bit 16+i, and bits 11 to 15 are never used. Each external pin is configured at build time as edge or level sensitive, and as active-high or active-low.

Software clears a recorded request by writing ones to an acknowledge register. A source can also be placed in fast mode. For such a source, the controller presents a per-source vector address next to the request line, taken from the highest-priority pending fast source. It then clears that source from a two-bit code the processor sends on handler entry, on return from interrupt or on re-enable of interrupts. Software takes no part in that clear.

Register access is a single-cycle write strobe with a word address. Read data is combinational from the address.

Top module: `vic_ctrl`

## Requirements
- R1: Internal source k sets status bit k and external input i sets status bit 16+i. Bits 11 to 15, internal bits at or above the internal count and external bits at or above 16 plus the external count always read 0. This includes the enable register at address 2. Status reads at address 0 and pending reads at address 1.
- R2: An edge-sensitive external input records exactly one event per active transition: rising when configured active-high, falling when configured active-low. The status bit is readable after the third rising clock edge following the transition. Holding the input, or making the opposite transition, records nothing.
- R3: A level-sensitive external input keeps setting its status bit while it is at its active level. An acknowledge made while the input is still active leaves the bit set. Once the input has been inactive for three clock edges, an acknowledge clears the bit.
- R4: Pending equals status ANDed with enable. The irq output is high exactly when some pending bit is set.
- R5: A write to address 3 clears every status bit whose data bit is 1, and a 0 data bit leaves the status bit unchanged. A new event arriving in the same cycle as the clear wins, and the bit stays set.
- R6: Address 4 is the write-only fast-mode mask. vec_addr shows the vector of the lowest-numbered source that is both pending and in fast mode, and shows 0 when there is no such source. Pending sources not in fast mode raise irq but leave vec_addr at 0.
- R7: On ack_code 01 the controller latches which fast source vec_addr names. On a later ack_code 10 or 11, that status bit is cleared and the latch is emptied. A code of 10 or 11 with nothing latched changes nothing, and 00 is idle.
- R8: Address 32+k writes the vector of source k, and the two lowest bits of any vector read back as 0 on vec_addr. Writes to the vector slot of a reserved or absent source change no stored vector.
- R9: After reset, status, enable, mode and vectors are 0, irq is low and vec_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src | input | N_INT | Internal interrupt strobes, one per source |
| ext_irq_in | input | N_EXT | External interrupt pins, possibly asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ack_code | input | 2 | Processor acknowledge code (00 idle, 01 enter, 10 return, 11 re-enable) |
| irq | output | 1 | Interrupt request to the processor |
| vec_addr | output | 32 | Vector address of the selected fast-mode source |

## Verification
The bench builds the block with three internal sources and four external pins. This gives one pin in each of the four combinations: falling edge, rising edge, active-high level and active-low level. Every sensitivity and polarity path is therefore exercised, and each pin idles at its own inactive level. With three internal sources, slot 3 and the reserved slot 12 become writable targets that must be ignored. Two internal fast sources and external pin 0 in fast mode let the lowest-index priority be seen when several fast sources pend together.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SRC_W    = 32;
    localparam int unsigned IDX_W    = $clog2(SRC_W);
    localparam int unsigned EXT_BASE = 16;
    localparam int unsigned MAX_INT  = 11;
    localparam int unsigned MAX_EXT  = 16;
    localparam int unsigned ADDR_W   = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // register word addresses
    localparam logic [ADDR_W-1:0] RA_STATUS = 6'd0;
    localparam logic [ADDR_W-1:0] RA_PEND   = 6'd1;
    localparam logic [ADDR_W-1:0] RA_ENABLE = 6'd2;
    localparam logic [ADDR_W-1:0] RA_CLEAR  = 6'd3;
    localparam logic [ADDR_W-1:0] RA_FAST   = 6'd4;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'b00,
        ACK_ENTER  = 2'b01,
        ACK_RETURN = 2'b10,
        ACK_REEN   = 2'b11
    } ack_code_e;

endpackage

// File: rtl/vic_ext_cond.sv
module vic_ext_cond #(
    parameter int unsigned N_EXT     = 4,
    parameter logic [15:0] EXT_LEVEL = 16'h000A,
    parameter logic [15:0] EXT_POS   = 16'h0006
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin,
    output logic [N_EXT-1:0] evt
);

    // idle value of every stage is the inactive level of its pin
    localparam logic [N_EXT-1:0] IDLE = ~EXT_POS[N_EXT-1:0];

    typedef struct packed {
        logic [N_EXT-1:0] meta;
        logic [N_EXT-1:0] sync;
        logic [N_EXT-1:0] prev;
    } cond_t;

    cond_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.meta = pin;
        c_d.sync = c_q.meta;
        c_d.prev = c_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{meta: IDLE, sync: IDLE, prev: IDLE};
        end else begin
            c_q <= c_d;
        end
    end

    for (genvar i = 0; i < int'(N_EXT); i++) begin : g_pin
        if (EXT_LEVEL[i]) begin : g_level
            if (EXT_POS[i]) begin : g_hi
                assign evt[i] = c_q.sync[i];
            end else begin : g_lo
                assign evt[i] = ~c_q.sync[i];
            end
        end else begin : g_edge
            if (EXT_POS[i]) begin : g_rise
                assign evt[i] = c_q.sync[i] & ~c_q.prev[i];
            end else begin : g_fall
                assign evt[i] = ~c_q.sync[i] & c_q.prev[i];
            end
        end
    end

endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  word_t req,
    output idx_t  idx,
    output logic  hit
);

    // lowest set index wins: scan downward so the last match is the lowest
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = int'(SRC_W) - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = idx_t'(i);
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned N_INT     = 4,
    parameter int unsigned N_EXT     = 4,
    parameter logic [15:0] EXT_LEVEL = 16'h000A,
    parameter logic [15:0] EXT_POS   = 16'h0006
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_src,
    input  logic [N_EXT-1:0] ext_irq_in,
    input  logic             reg_wr,
    input  logic [5:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [1:0]       ack_code,
    output logic             irq,
    output logic [31:0]      vec_addr
);

    localparam word_t INT_MASK = (word_t'(1) << N_INT) - word_t'(1);
    localparam word_t EXT_MASK = ((word_t'(1) << N_EXT) - word_t'(1)) << EXT_BASE;
    localparam word_t VALID    = INT_MASK | EXT_MASK;
    localparam int unsigned VW = WORD_W - 2;

    typedef struct packed {
        word_t                    status;
        word_t                    enable;
        word_t                    fast;
        logic [SRC_W-1:0][VW-1:0] vec;
        logic                     act_vld;
        idx_t                     act_idx;
    } vic_state_t;

    vic_state_t st_d, st_q;

    logic [N_EXT-1:0] ext_evt;
    word_t            evt_all;
    word_t            pend;
    word_t            fast_pend;
    word_t            clr;
    idx_t             sel_idx;
    logic             sel_hit;

    vic_ext_cond #(
        .N_EXT    (N_EXT),
        .EXT_LEVEL(EXT_LEVEL),
        .EXT_POS  (EXT_POS)
    ) u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_irq_in),
        .evt  (ext_evt)
    );

    assign evt_all   = word_t'(int_src) | (word_t'(ext_evt) << EXT_BASE);
    assign pend      = st_q.status & st_q.enable;
    assign fast_pend = pend & st_q.fast;

    vic_prio u_prio (
        .req(fast_pend),
        .idx(sel_idx),
        .hit(sel_hit)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;

        if (reg_wr) begin
            case (reg_addr)
                RA_ENABLE: st_d.enable = reg_wdata & VALID;
                RA_CLEAR:  clr         = reg_wdata;
                RA_FAST:   st_d.fast   = reg_wdata & VALID;
                default: begin
                    if (reg_addr[5] && VALID[reg_addr[4:0]]) begin
                        st_d.vec[reg_addr[4:0]] = reg_wdata[31:2];
                    end
                end
            endcase
        end

        case (ack_code_e'(ack_code))
            ACK_ENTER: begin
                st_d.act_vld = sel_hit;
                st_d.act_idx = sel_idx;
            end
            ACK_RETURN, ACK_REEN: begin
                if (st_q.act_vld) begin
                    clr[st_q.act_idx] = 1'b1;
                end
                st_d.act_vld = 1'b0;
            end
            default: ;
        endcase

        // a fresh event in the clearing cycle is kept
        st_d.status = ((st_q.status & ~clr) | evt_all) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq      = |pend;
    assign vec_addr = sel_hit ? {st_q.vec[sel_idx], 2'b00} : '0;

    always_comb begin
        case (reg_addr)
            RA_STATUS: reg_rdata = st_q.status;
            RA_PEND:   reg_rdata = pend;
            RA_ENABLE: reg_rdata = st_q.enable;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [1:0]  ack_code,
    input logic        irq,
    input logic [31:0] vec_addr,
    input logic [31:0] status,
    input logic [31:0] evt,
    input logic        act_vld,
    input logic [4:0]  act_idx
);

    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 6'd3) |=> ((status & $past(reg_wdata) & ~$past(evt)) == 32'd0)); // R5

    AST_VEC_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_addr != 32'd0) |-> irq); // R6

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[1:0] == 2'b00); // R8

    AST_ENTER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_code == 2'b01 && vec_addr != 32'd0) |=> act_vld); // R7

    AST_FAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_code[1] && act_vld && !evt[act_idx]) |=> !status[$past(act_idx)]); // R7

    AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != 32'd0)); // R4

endmodule

bind vic_ctrl vic_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .ack_code (ack_code),
    .irq      (irq),
    .vec_addr (vec_addr),
    .status   (st_q.status),
    .evt      (evt_all),
    .act_vld  (st_q.act_vld),
    .act_idx  (st_q.act_idx)
);

// File: tb/vic_ctrl_test.sv
`timescale 1ns/1ps
module vic_ctrl_test;

    localparam int unsigned NI = 3;
    localparam int unsigned NE = 4;
    // pin0 falling edge, pin1 high level, pin2 rising edge, pin3 low level
    localparam logic [NE-1:0] IDLE = 4'b1001;

    localparam logic [5:0] A_ST = 6'd0, A_PE = 6'd1, A_EN = 6'd2, A_CL = 6'd3, A_FM = 6'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] int_src = '0;
    logic [NE-1:0] ext_irq_in = IDLE;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [1:0]    ack_code = 2'b00;
    logic          irq;
    logic [31:0]   vec_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vic_ctrl #(
        .N_INT(NI), .N_EXT(NE), .EXT_LEVEL(16'h000A), .EXT_POS(16'h0006)
    ) uut (
        .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_irq_in(ext_irq_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_code(ack_code), .irq(irq), .vec_addr(vec_addr)
    );

    typedef struct packed {
        logic [1:0]  k;
        logic [5:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } step_t;

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_PU = 2'd2, K_IQ = 2'd3;

    localparam step_t TBL [15] = '{
        '{K_PU, 6'd0, 32'h5,        32'h0},
        '{K_RD, A_ST, 32'h0,        32'h5},
        '{K_RD, A_PE, 32'h0,        32'h0},
        '{K_IQ, 6'd0, 32'h0,        32'h0},
        '{K_WR, A_EN, 32'hFFFFFFFF, 32'h0},
        '{K_RD, A_EN, 32'h0,        32'h000F0007},
        '{K_RD, A_PE, 32'h0,        32'h5},
        '{K_IQ, 6'd0, 32'h0,        32'h1},
        '{K_WR, A_CL, 32'h4,        32'h0},
        '{K_RD, A_ST, 32'h0,        32'h1},
        '{K_WR, A_CL, 32'h0,        32'h0},
        '{K_RD, A_ST, 32'h0,        32'h1},
        '{K_WR, A_EN, 32'h0,        32'h0},
        '{K_RD, A_PE, 32'h0,        32'h0},
        '{K_IQ, 6'd0, 32'h0,        32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse(input logic [NI-1:0] v);
        int_src = v;
        tick();
        int_src = '0;
    endtask

    task automatic ack(input logic [1:0] c);
        ack_code = c;
        tick();
        ack_code = 2'b00;
    endtask

    task automatic pin(input logic [NE-1:0] v);
        ext_irq_in = v;
        repeat (3) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd("R9 status", A_ST, 32'h0);
        rd("R9 enable", A_EN, 32'h0);
        chk("R9 irq", {31'd0, irq}, 32'h0);
        chk("R9 vec_addr", vec_addr, 32'h0);

        // R1/R4/R5 table walk
        for (int i = 0; i < 15; i++) begin
            case (TBL[i].k)
                K_WR: wr(TBL[i].a, TBL[i].d);
                K_RD: rd($sformatf("R1/R4/R5 table step %0d", i), TBL[i].a, TBL[i].e);
                K_PU: pulse(TBL[i].d[NI-1:0]);
                default: begin
                    #1;
                    chk($sformatf("R4 table irq step %0d", i), {31'd0, irq}, TBL[i].e);
                end
            endcase
        end

        wr(A_EN, 32'hFFFFFFFF);
        wr(A_CL, 32'hFFFFFFFF);

        // R2 rising edge on pin 2
        pin(IDLE | 4'b0100);
        rd("R2 rise sets bit 18", A_ST, 32'h0004_0000);
        wr(A_CL, 32'h0004_0000);
        repeat (3) tick();
        rd("R2 held high no re-event", A_ST, 32'h0);
        pin(IDLE);
        rd("R2 falling on rising pin ignored", A_ST, 32'h0);

        // R2 falling edge on pin 0
        pin(IDLE & 4'b1110);
        rd("R2 fall sets bit 16", A_ST, 32'h0001_0000);
        #1 chk("R4 irq from pin 0", {31'd0, irq}, 32'h1);
        pin(IDLE);
        wr(A_CL, 32'h0001_0000);
        rd("R2 rise on falling pin ignored", A_ST, 32'h0);

        // R3 active-high level on pin 1
        pin(IDLE | 4'b0010);
        rd("R3 level sets bit 17", A_ST, 32'h0002_0000);
        wr(A_CL, 32'h0002_0000);
        rd("R3 still active sets again", A_ST, 32'h0002_0000);
        pin(IDLE);
        wr(A_CL, 32'h0002_0000);
        rd("R3 released then cleared", A_ST, 32'h0);

        // R3 active-low level on pin 3
        pin(IDLE & 4'b0111);
        rd("R3 low level sets bit 19", A_ST, 32'h0008_0000);
        pin(IDLE);
        wr(A_CL, 32'h0008_0000);
        rd("R3 low level cleared", A_ST, 32'h0);

        // R6/R7/R8 fast mode
        wr(6'd33, 32'h0000_1003);
        wr(6'd34, 32'h0000_2000);
        wr(6'd48, 32'h0000_3000);
        wr(6'd44, 32'hDEAD_0000);
        wr(6'd57, 32'hBEEF_0000);
        wr(6'd35, 32'h7000_0000);
        wr(A_FM, 32'h0001_0006);
        #1 chk("R6 nothing pending", vec_addr, 32'h0);
        pulse(3'b100);
        #1 chk("R6 single fast source", vec_addr, 32'h0000_2000);
        pulse(3'b010);
        #1 chk("R6 lowest index wins, R8 low bits zero", vec_addr, 32'h0000_1000);
        ack(2'b01);
        #1 chk("R7 enter keeps status", vec_addr, 32'h0000_1000);
        ack(2'b10);
        rd("R7 return clears latched bit", A_ST, 32'h4);
        #1 chk("R7 next vector", vec_addr, 32'h0000_2000);
        ack(2'b10);
        rd("R7 return with nothing latched", A_ST, 32'h4);
        ack(2'b01);
        ack(2'b11);
        rd("R7 re-enable clears", A_ST, 32'h0);
        #1 chk("R7 irq dropped", {31'd0, irq}, 32'h0);
        chk("R7 vec dropped", vec_addr, 32'h0);

        pin(IDLE & 4'b1110);
        #1 chk("R8 external slot 16 vector", vec_addr, 32'h0000_3000);
        pin(IDLE);
        wr(A_CL, 32'hFFFFFFFF);

        pulse(3'b001);
        #1 chk("R6 non-fast raises irq", {31'd0, irq}, 32'h1);
        chk("R6 non-fast leaves vec zero", vec_addr, 32'h0);
        wr(A_CL, 32'hFFFFFFFF);

        // R5 event beats clear in the same cycle
        reg_wr = 1'b1; reg_addr = A_CL; reg_wdata = 32'h1; int_src = 3'b001;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; int_src = '0;
        rd("R5 set wins over clear", A_ST, 32'h1);

        // R9 reset mid-run
        rst_n = 1'b0;
        #1;
        rst_n = 1'b1;
        tick();
        rd("R9 enable after reset", A_EN, 32'h0);
        rd("R9 status after reset", A_ST, 32'h0);

        finish_run();
    end

endmodule